// File: doc/BRIEF.md
# CPU Presence Bitmap Port

This block keeps a record of which processors are present in a system, one bit per processor, with the bit position equal to that processor's APIC ID. Firmware reads the record through a small byte-wide I/O window of 32 bytes. Byte offset k returns the presence bits of IDs 8k to 8k+7. When a processor is added, the hot-add input sets the matching bit. It also latches a general-purpose event status flag and, if that event is enabled, holds a level system control interrupt until firmware clears the flag.

The window's contents are read-only, with one exception: a write pattern that hands control to a newer selector-based hotplug interface. A zero written to each of the four bytes of the first 32-bit word, in any order, performs the handoff. After it, the block stops answering window accesses and drops its legacy mode flag, so that the newer register block can serve the address range. The handoff is one-way until reset. Presence bits are never cleared, because hot-remove does not exist in this scheme.

Top module: `cpu_present_port`

## Requirements
- R1: After reset every presence bit is 0, gpe_sts_o is 0, sci_o is 0, rd_valid_o is 0 and legacy_mode_o is 1.
- R2: A read accepted at byte offset k raises rd_valid_o one cycle later, and rd_data_o bit i then equals the presence of ID 8k+i as it was before that edge. Bits for IDs at or above NUM_CPUS read 0.
- R3: Window writes never change any presence bit.
- R4: A hot-add request with ID below NUM_CPUS sets that ID's presence bit, and the bit stays set until reset.
- R5: A hot-add request with ID at or above NUM_CPUS changes no presence bit and does not touch gpe_sts_o.
- R6: An accepted hot-add sets gpe_sts_o bit 2 (all other bits read 0). A clear strobe with gpe_wdata_i bit 2 at 1 clears it, and a hot-add in the same cycle wins over the clear.
- R7: sci_o is 1 exactly when gpe_sts_o bit 2 and the enable bit are both 1. The enable bit is loaded from gpe_wdata_i bit 2 by an enable-write strobe and resets to 0.
- R8: Once zero bytes have been written to offsets 0, 1, 2 and 3 (in any order, repeats allowed), legacy_mode_o falls after the clock edge that takes the last of them. A nonzero write to any of those offsets restarts the collection.
- R9: Once legacy_mode_o is 0 it stays 0, reads no longer raise rd_valid_o, and window writes have no effect.
- R10: Writes to offsets 4 to 31, with any data, neither advance nor restart the handoff collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hp_valid_i | input | 1 | Hot-add request strobe |
| hp_id_i | input | ID_W | APIC ID of the added processor |
| acc_valid_i | input | 1 | Window access strobe |
| acc_we_i | input | 1 | 1 for write, 0 for read |
| acc_addr_i | input | ADDR_W | Byte offset inside the window |
| acc_wdata_i | input | 8 | Write data byte |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read |
| rd_data_o | output | 8 | Read data byte |
| gpe_clr_i | input | 1 | Status write-1-to-clear strobe |
| gpe_en_wr_i | input | 1 | Event enable write strobe |
| gpe_wdata_i | input | 8 | Data for the status clear and the enable write |
| gpe_sts_o | output | 8 | Event status byte, bit 2 is the hot-add event |
| sci_o | output | 1 | Level system control interrupt |
| legacy_mode_o | output | 1 | 1 while the bitmap window is active |

## Verification
The assertions assume that NUM_CPUS does not exceed 2 to the power ID_W, that hot-add requests arrive at most one per cycle, and that the inputs are free of X after reset. The bench drives every input at the falling edge from tasks, so each value holds for a whole cycle around the rising edge. Out-of-range IDs are sent on purpose. During the random phase, writes to the first word always carry nonzero data, so the handoff takes place only in the directed sequence, where the checks expect it.

// File: rtl/cpu_present_pkg.sv
package cpu_present_pkg;
  localparam int BYTE_W  = 8;
  localparam int EVT_BIT = 2;

  typedef enum logic {
    MODE_LEGACY   = 1'b0,
    MODE_SELECTOR = 1'b1
  } port_mode_e;
endpackage

// File: rtl/cpu_present_store.sv
module cpu_present_store #(
  parameter int NUM_CPUS = 200,
  parameter int ID_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                add_valid_i,
  input  logic [ID_W-1:0]     add_id_i,
  output logic                accepted_o,
  output logic [NUM_CPUS-1:0] present_o
);
  localparam logic [ID_W:0] ID_LIM = (ID_W+1)'(NUM_CPUS);

  logic [NUM_CPUS-1:0] present_q;

  assign accepted_o = add_valid_i && ({1'b0, add_id_i} < ID_LIM);

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      present_q[g] <= 1'b0;
      else if (accepted_o && add_id_i == ID_W'(g))      present_q[g] <= 1'b1;
    end
  end

  assign present_o = present_q;

  // R4: no presence bit ever falls
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((present_q & $past(present_q)) == $past(present_q)));

  // R5: out-of-range IDs leave the map untouched
  a_r5_oob_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_valid_i && ({1'b0, add_id_i} >= ID_LIM)) |=> $stable(present_q));

  // R4: accepted ID is present afterwards
  a_r4_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted_o |=> (present_q != '0));
endmodule

// File: rtl/cpu_evt_latch.sv
module cpu_evt_latch
  import cpu_present_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              en_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] sts_o,
  output logic              sci_o
);
  logic sts_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (set_i)                        sts_q <= 1'b1;
      else if (clr_i && wdata_i[EVT_BIT]) sts_q <= 1'b0;
      if (en_wr_i)                      en_q  <= wdata_i[EVT_BIT];
    end
  end

  always_comb begin
    sts_o          = '0;
    sts_o[EVT_BIT] = sts_q;
  end

  assign sci_o = sts_q & en_q;

  // R6: set has priority
  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> sts_o[EVT_BIT]);

  // R6: clear without set drops the flag
  a_r6_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && wdata_i[EVT_BIT] && !set_i) |=> !sts_o[EVT_BIT]);

  // R7: interrupt never without status
  a_r7_sci_needs_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> sts_o[EVT_BIT]);
endmodule

// File: rtl/cpu_mode_switch.sv
module cpu_mode_switch
  import cpu_present_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              legacy_o
);
  localparam int SEL_W = $clog2(WORD_BYTES);

  port_mode_e            mode_q;
  logic [WORD_BYTES-1:0] seen_q, seen_d;
  logic                  hit;

  assign hit = wr_i && (mode_q == MODE_LEGACY) && (addr_i < ADDR_W'(WORD_BYTES));

  always_comb begin
    seen_d = seen_q;
    if (hit) begin
      if (data_i == '0) seen_d[addr_i[SEL_W-1:0]] = 1'b1;
      else              seen_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_LEGACY;
      seen_q <= '0;
    end else if (mode_q == MODE_LEGACY) begin
      seen_q <= seen_d;
      if (&seen_d) mode_q <= MODE_SELECTOR;
    end
  end

  assign legacy_o = (mode_q == MODE_LEGACY);

  // R9: handoff is one-way
  a_r9_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_o |=> !legacy_o);

  // R10: writes above the first word leave the collection alone
  a_r10_high_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_o && !(wr_i && addr_i < ADDR_W'(WORD_BYTES))) |=> $stable(seen_q));

  // R8: nonzero write to first word restarts
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && data_i != '0) |=> (seen_q == '0));
endmodule

// File: rtl/cpu_present_port.sv
module cpu_present_port
  import cpu_present_pkg::*;
#(
  parameter int NUM_CPUS   = 200,
  parameter int ID_W       = 8,
  parameter int WIN_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  localparam int ADDR_W    = $clog2(WIN_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hp_valid_i,
  input  logic [ID_W-1:0]   hp_id_i,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [7:0]        acc_wdata_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  input  logic              gpe_clr_i,
  input  logic              gpe_en_wr_i,
  input  logic [7:0]        gpe_wdata_i,
  output logic [7:0]        gpe_sts_o,
  output logic              sci_o,
  output logic              legacy_mode_o
);
  localparam int WIN_BITS = WIN_BYTES * BYTE_W;

  logic [NUM_CPUS-1:0] present;
  logic [WIN_BITS-1:0] win_bits;
  logic                hp_accepted;
  logic                legacy;
  logic                rd_valid_q;
  logic [BYTE_W-1:0]   rd_data_q;

  cpu_present_store #(.NUM_CPUS(NUM_CPUS), .ID_W(ID_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .add_valid_i (hp_valid_i),
    .add_id_i    (hp_id_i),
    .accepted_o  (hp_accepted),
    .present_o   (present)
  );

  cpu_evt_latch u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (hp_accepted),
    .clr_i   (gpe_clr_i),
    .en_wr_i (gpe_en_wr_i),
    .wdata_i (gpe_wdata_i),
    .sts_o   (gpe_sts_o),
    .sci_o   (sci_o)
  );

  cpu_mode_switch #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (acc_valid_i && acc_we_i),
    .addr_i   (acc_addr_i),
    .data_i   (acc_wdata_i),
    .legacy_o (legacy)
  );

  // pad the map out to the window size
  for (genvar b = 0; b < WIN_BITS; b++) begin : g_win
    if (b < NUM_CPUS) begin : g_live
      assign win_bits[b] = present[b];
    end else begin : g_pad
      assign win_bits[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= acc_valid_i && !acc_we_i && legacy;
      rd_data_q  <= (acc_valid_i && !acc_we_i && legacy)
                    ? win_bits[{acc_addr_i, 3'b000} +: BYTE_W] : '0;
    end
  end

  assign rd_valid_o    = rd_valid_q;
  assign rd_data_o     = rd_data_q;
  assign legacy_mode_o = legacy;

  // R9: no read response after handoff
  a_r9_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legacy_mode_o |=> !rd_valid_o);

  // R2: a read in legacy mode is answered next cycle
  a_r2_read_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_we_i && legacy_mode_o) |=> rd_valid_o);
endmodule

// File: tb/cpu_present_port_test.sv
`timescale 1ns/1ps
module cpu_present_port_test;
  localparam int NCPU = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hp_valid = 1'b0;
  logic [7:0] hp_id = '0;
  logic       acc_valid = 1'b0, acc_we = 1'b0;
  logic [4:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       gpe_clr = 1'b0, gpe_en_wr = 1'b0;
  logic [7:0] gpe_wdata = '0;
  logic [7:0] gpe_sts;
  logic       sci, legacy;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_present_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hp_valid_i(hp_valid), .hp_id_i(hp_id),
    .acc_valid_i(acc_valid), .acc_we_i(acc_we), .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .gpe_clr_i(gpe_clr), .gpe_en_wr_i(gpe_en_wr), .gpe_wdata_i(gpe_wdata),
    .gpe_sts_o(gpe_sts), .sci_o(sci), .legacy_mode_o(legacy)
  );

  // behavioural reference
  bit       m_pres [256];
  bit       m_sts, m_en, m_leg;
  bit       m_seen [4];
  bit       m_rv;
  int       m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pres[i]) m_pres[i] = 1'b0;
      foreach (m_seen[i]) m_seen[i] = 1'b0;
      m_sts = 0; m_en = 0; m_leg = 1; m_rv = 0; m_rd = 0;
    end else begin
      bit rd_now;
      int byte_v;
      rd_now = acc_valid && !acc_we && m_leg;
      byte_v = 0;
      for (int i = 0; i < 8; i++)
        if (m_pres[int'(acc_addr) * 8 + i]) byte_v += (1 << i);
      m_rv = rd_now;
      m_rd = rd_now ? byte_v : 0;
      if (acc_valid && acc_we && m_leg && int'(acc_addr) < 4) begin
        if (acc_wdata == 0) m_seen[int'(acc_addr)] = 1'b1;
        else foreach (m_seen[i]) m_seen[i] = 1'b0;
        if (m_seen[0] && m_seen[1] && m_seen[2] && m_seen[3]) m_leg = 0;
      end
      if (gpe_clr && gpe_wdata[2]) m_sts = 0;
      if (hp_valid && int'(hp_id) < NCPU) begin
        m_pres[int'(hp_id)] = 1'b1;
        m_sts = 1;
      end
      if (gpe_en_wr) m_en = gpe_wdata[2];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle
  always @(negedge clk) if (rst_n && !done) begin
    chk("R9 rd_valid", int'(rd_valid), int'(m_rv));
    if (m_rv) chk("R2 rd_data", int'(rd_data), m_rd);
    chk("R6 gpe_sts", int'(gpe_sts), m_sts ? 4 : 0);
    chk("R7 sci", int'(sci), int'(m_sts && m_en));
    chk("R8 legacy", int'(legacy), int'(m_leg));
  end

  task automatic idle();
    hp_valid = 0; acc_valid = 0; acc_we = 0; gpe_clr = 0; gpe_en_wr = 0;
  endtask

  task automatic hot_add(int id);
    hp_valid = 1; hp_id = 8'(id);
    @(negedge clk); idle();
  endtask

  task automatic wr(int a, int d);
    acc_valid = 1; acc_we = 1; acc_addr = 5'(a); acc_wdata = 8'(d);
    @(negedge clk); idle();
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    acc_valid = 1; acc_we = 0; acc_addr = 5'(a);
    @(negedge clk); idle();
    chk(tag, int'(rd_valid), 1);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic gpe(bit clr, bit en, int d);
    gpe_clr = clr; gpe_en_wr = en; gpe_wdata = 8'(d);
    @(negedge clk); idle();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sts", int'(gpe_sts), 0);
    chk("R1 sci", int'(sci), 0);
    chk("R1 legacy", int'(legacy), 1);
    chk("R1 rd_valid", int'(rd_valid), 0);
    rd_chk("R1 map", 3, 0);

    // R4 / R2 hot-add and byte layout
    hot_add(0); hot_add(7); hot_add(8); hot_add(199); hot_add(63);
    rd_chk("R2 byte0", 0, 8'h81);
    rd_chk("R2 byte1", 1, 8'h01);
    rd_chk("R2 byte7", 7, 8'h80);
    rd_chk("R2 byte24", 24, 8'h80);
    hot_add(0);
    rd_chk("R4 sticky", 0, 8'h81);

    // R7 enable and interrupt
    chk("R6 sts set", int'(gpe_sts), 4);
    chk("R7 sci off", int'(sci), 0);
    gpe(0, 1, 4);
    chk("R7 sci on", int'(sci), 1);
    gpe(1, 0, 4);
    chk("R6 cleared", int'(gpe_sts), 0);
    chk("R7 sci low", int'(sci), 0);

    // R5 out of range
    hot_add(200); hot_add(255);
    chk("R5 no event", int'(gpe_sts), 0);
    rd_chk("R5 pad byte", 25, 0);

    // R6 set beats clear
    hp_valid = 1; hp_id = 8'd100; gpe_clr = 1; gpe_wdata = 8'h04;
    @(negedge clk); idle();
    chk("R6 set wins", int'(gpe_sts), 4);
    gpe(1, 0, 8'hFB);
    chk("R6 bit2 only", int'(gpe_sts), 4);

    // R3 writes do not alter the map
    wr(0, 8'hFF); wr(12, 8'h00); wr(25, 8'hAA);
    rd_chk("R3 byte0", 0, 8'h81);
    rd_chk("R3 byte12", 12, 8'h10);

    // random phase, no handoff
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin hp_valid = 1; hp_id = 8'($urandom); end
        1: begin acc_valid = 1; acc_we = 0; acc_addr = 5'($urandom); end
        2: begin
             acc_valid = 1; acc_we = 1; acc_addr = 5'($urandom);
             acc_wdata = 8'($urandom_range(1, 255));
           end
        3: begin gpe_clr = 1; gpe_wdata = 8'($urandom); end
        4: begin gpe_en_wr = 1; gpe_wdata = 8'($urandom); end
        default: ;
      endcase
      @(negedge clk); idle();
    end
    chk("R8 still legacy", int'(legacy), 1);

    // R8 / R10 handoff
    wr(0, 0); wr(1, 0); wr(2, 0);
    wr(5, 0); wr(31, 8'h55);
    chk("R10 no effect", int'(legacy), 1);
    wr(1, 8'h05);
    wr(3, 0);
    chk("R8 restarted", int'(legacy), 1);
    wr(2, 0); wr(2, 0); wr(1, 0);
    chk("R8 three of four", int'(legacy), 1);
    wr(0, 0);
    chk("R8 switched", int'(legacy), 0);

    // R9 after handoff
    acc_valid = 1; acc_we = 0; acc_addr = 5'd0;
    @(negedge clk); idle();
    chk("R9 no read", int'(rd_valid), 0);
    wr(0, 8'h12); wr(1, 0);
    chk("R9 one way", int'(legacy), 0);
    hot_add(10);
    chk("R9 events live", int'(gpe_sts), 4);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule